// File: doc/BRIEF.md
# ADC Calibration Sequencer and Result Corrector

This block is the calibration and correction stage of a sigma-delta converter's digital back end. It takes raw conversion samples on a valid-strobed input and a 3-bit mode field. A calibration code starts one of four calibration runs: internal or system, zero-scale or full-scale. The run counts incoming output-rate samples. The number of samples depends on the filter order, the chop setting, the gain and the kind of calibration. When the count is reached, the last sample becomes the new offset or gain coefficient, the busy flag drops and the block goes back to idle.

In continuous or single-conversion mode, every raw sample is corrected before it is presented. The offset coefficient is subtracted first. The difference is then scaled by the gain coefficient, an unsigned fixed-point value whose unity is half of full range. The result is re-centred on bipolar midscale and saturated. Both coefficients can be read at all times. A host may overwrite them only while the block is idle or powered down. Two sticky flags record a refused internal full-scale calibration and a refused coefficient write.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset the mode reads 010 (idle), busy is 0, both sticky error flags are 0, res_valid is 0, and both coefficients read 0x800000.
- R2: Writing a calibration code (100 internal zero-scale, 110 system zero-scale, 101 internal full-scale, 111 system full-scale) that is not refused sets busy and shows that code on the mode output from the next cycle. While busy is 1, the mode output holds a code with bit 2 set.
- R3: Zero-scale calibrations (100 and 110) take the settle count of samples. The settle count is 2 with chop on; with chop off it is 4 for the fourth-order filter (sinc3_sel=0) and 3 for the third-order filter (sinc3_sel=1).
- R4: The system full-scale calibration (111) takes the settle count of samples. The internal full-scale calibration (101) takes the settle count at unity gain (gain_one=1) and twice the settle count otherwise.
- R5: On the cycle after the last counted sample, busy is 0 and the mode is 010. The offset coefficient (zero-scale runs) or the gain coefficient (full-scale runs) then equals that last sample.
- R6: A write of 101 is refused when filt_word is not a multiple of 16. After a refused write the mode is 010, busy is 0, cal_err is 1 and stays 1, and both coefficients are unchanged.
- R7: In mode 000 (continuous) or 001 (single), a raw sample gives res_valid=1 on the next cycle. The result is clamp(0x800000 + floor((raw - off) * fs / 2^23)), with raw and off as unsigned values.
- R8: Corrected values below 0 saturate to 0x000000, and values above 0xFFFFFF saturate to 0xFFFFFF.
- R9: In single mode the block returns to mode 010 after one corrected sample. Samples that arrive in idle, power-down or calibration modes produce no res_valid.
- R10: A coefficient write (coef_sel_fs=0 selects offset, 1 selects gain) in mode 010 or 011 appears on the coefficient output on the next cycle.
- R11: A coefficient write in mode 000 or 001 leaves both coefficients unchanged and sets the sticky wr_err flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode code to write |
| filt_word | input | FW | Filter rate word |
| sinc3_sel | input | 1 | 1 selects third-order filter timing, 0 fourth-order |
| chop_en | input | 1 | Chop enabled |
| gain_one | input | 1 | 1 when the programmed gain is unity |
| raw_valid | input | 1 | Raw sample strobe (one per output period) |
| raw_data | input | DW | Raw conversion sample, offset binary |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_sel_fs | input | 1 | 0 offset, 1 gain coefficient |
| coef_wdata | input | DW | Coefficient write data |
| mode | output | 3 | Current mode code |
| busy | output | 1 | Calibration in progress |
| cal_err | output | 1 | Sticky: internal full-scale request refused |
| wr_err | output | 1 | Sticky: coefficient write refused |
| off_coef | output | DW | Offset coefficient |
| fs_coef | output | DW | Gain coefficient |
| res_valid | output | 1 | Corrected result strobe |
| res_data | output | DW | Corrected result |

## Verification
Every strobe takes effect at one clock edge. Busy, mode, the error flags and the coefficients change one cycle after a mode or coefficient write. res_valid and res_data appear one cycle after the raw strobe, and a calibration ends one cycle after its final counted sample. The bench drives each strobe for exactly one cycle from a falling edge and checks at the next falling edge, so every result is sampled in the cycle it is due. During each calibration, busy is checked after every sample, which pins the duration to the exact sample count.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
   typedef enum logic [2:0] {
      M_CONT   = 3'b000,
      M_SINGLE = 3'b001,
      M_IDLE   = 3'b010,
      M_PDOWN  = 3'b011,
      M_IZS    = 3'b100,
      M_IFS    = 3'b101,
      M_SZS    = 3'b110,
      M_SFS    = 3'b111
   } mode_e;
endpackage

// File: rtl/adc_cal_timer.sv
module adc_cal_timer #(
   parameter int S4    = 4,
   parameter int S3    = 3,
   parameter int SCHOP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic kind_fs,
   input  logic kind_int,
   input  logic sinc3,
   input  logic chop,
   input  logic gain_one,
   input  logic smp,
   output logic busy,
   output logic done
);
   localparam int MAXS = (S4 > S3) ? ((S4 > SCHOP) ? S4 : SCHOP) : ((S3 > SCHOP) ? S3 : SCHOP);
   localparam int CW   = $clog2(2 * MAXS + 1);

   if (S4 < 1 || S3 < 1 || SCHOP < 1) begin : g_bad_settle
      $error("settle counts must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] settle;
   logic [CW-1:0] dur;

   always_comb begin
      settle = chop ? CW'(SCHOP) : (sinc3 ? CW'(S3) : CW'(S4));
      dur    = (kind_fs && kind_int && !gain_one) ? (settle << 1) : settle;
   end

   assign done = busy && smp && (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
      end else if (start) begin
         cnt  <= dur;
         busy <= 1'b1;
      end else if (abort || done) begin
         cnt  <= '0;
         busy <= 1'b0;
      end else if (busy && smp) begin
         cnt <= cnt - CW'(1);
      end
   end
endmodule

// File: rtl/adc_cal_coef.sv
module adc_cal_coef #(
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_fs,
   input  logic [DW-1:0] wdata,
   input  logic          cap_en,
   input  logic          cap_fs,
   input  logic [DW-1:0] cap_data,
   output logic [DW-1:0] off_q,
   output logic [DW-1:0] fs_q
);
   localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= HALF;
         fs_q  <= HALF;
      end else if (cap_en) begin
         if (cap_fs) fs_q  <= cap_data;
         else        off_q <= cap_data;
      end else if (wr_en) begin
         if (wr_fs) fs_q  <= wdata;
         else       off_q <= wdata;
      end
   end
endmodule

// File: rtl/adc_cal_corr.sv
module adc_cal_corr #(
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] raw,
   input  logic [DW-1:0] off,
   input  logic [DW-1:0] fs,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);
   localparam int PW = 2 * DW + 2;
   localparam logic signed [PW-1:0] MID  = {{(PW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};
   localparam logic signed [PW-1:0] MAXV = {{(PW-DW){1'b0}}, {DW{1'b1}}};

   logic signed [DW:0]   diff;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] scaled;
   logic [DW-1:0]        sat;

   always_comb begin
      diff   = $signed({1'b0, raw}) - $signed({1'b0, off});
      prod   = {{(PW-DW-1){diff[DW]}}, diff} * {{(PW-DW){1'b0}}, fs};
      scaled = (prod >>> (DW - 1)) + MID;
      if (scaled[PW-1])       sat = '0;
      else if (scaled > MAXV) sat = '1;
      else                    sat = scaled[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= sat;
      end
   end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
   import adc_cal_pkg::*;
#(
   parameter int DW       = 24,
   parameter int FW       = 10,
   parameter int FS_ALIGN = 16,
   parameter int S4       = 4,
   parameter int S3       = 3,
   parameter int SCHOP    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_wr,
   input  logic [2:0]    mode_in,
   input  logic [FW-1:0] filt_word,
   input  logic          sinc3_sel,
   input  logic          chop_en,
   input  logic          gain_one,
   input  logic          raw_valid,
   input  logic [DW-1:0] raw_data,
   input  logic          coef_wr,
   input  logic          coef_sel_fs,
   input  logic [DW-1:0] coef_wdata,
   output logic [2:0]    mode,
   output logic          busy,
   output logic          cal_err,
   output logic          wr_err,
   output logic [DW-1:0] off_coef,
   output logic [DW-1:0] fs_coef,
   output logic          res_valid,
   output logic [DW-1:0] res_data
);
   if (DW < 8) begin : g_bad_dw
      $error("DW must be at least 8");
   end
   if (FS_ALIGN < 2 || FS_ALIGN >= (1 << FW)) begin : g_bad_align
      $error("FS_ALIGN out of range");
   end

   mode_e mode_q;
   logic  aligned, refuse, cal_start, done, conv, wr_ok;

   if ((FS_ALIGN & (FS_ALIGN - 1)) == 0) begin : g_align_mask
      localparam int AB = $clog2(FS_ALIGN);
      assign aligned = (filt_word[AB-1:0] == '0);
   end else begin : g_align_mod
      assign aligned = ((filt_word % FW'(FS_ALIGN)) == '0);
   end

   assign refuse    = (mode_in == M_IFS) && !aligned;
   assign cal_start = mode_wr && mode_in[2] && !refuse;
   assign conv      = raw_valid && (mode_q == M_CONT || mode_q == M_SINGLE);
   assign wr_ok     = (mode_q == M_IDLE) || (mode_q == M_PDOWN);

   adc_cal_timer #(.S4(S4), .S3(S3), .SCHOP(SCHOP)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cal_start),
      .abort    (mode_wr),
      .kind_fs  (mode_in[0]),
      .kind_int (!mode_in[1]),
      .sinc3    (sinc3_sel),
      .chop     (chop_en),
      .gain_one (gain_one),
      .smp      (raw_valid),
      .busy     (busy),
      .done     (done)
   );

   adc_cal_coef #(.DW(DW)) u_coef (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (coef_wr && wr_ok),
      .wr_fs    (coef_sel_fs),
      .wdata    (coef_wdata),
      .cap_en   (done),
      .cap_fs   (mode_q[0]),
      .cap_data (raw_data),
      .off_q    (off_coef),
      .fs_q     (fs_coef)
   );

   adc_cal_corr #(.DW(DW)) u_corr (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (conv),
      .raw       (raw_data),
      .off       (off_coef),
      .fs        (fs_coef),
      .out_valid (res_valid),
      .out_data  (res_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= M_IDLE;
         cal_err <= 1'b0;
         wr_err  <= 1'b0;
      end else begin
         if (mode_wr)
            mode_q <= refuse ? M_IDLE : mode_e'(mode_in);
         else if (done || (conv && mode_q == M_SINGLE))
            mode_q <= M_IDLE;
         if (mode_wr && refuse)   cal_err <= 1'b1;
         if (coef_wr && !wr_ok)   wr_err  <= 1'b1;
      end
   end

   assign mode = mode_q;
endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk #(
   parameter int DW       = 24,
   parameter int FW       = 10,
   parameter int FS_ALIGN = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_wr,
   input logic [2:0]    mode_in,
   input logic [FW-1:0] filt_word,
   input logic          raw_valid,
   input logic          coef_wr,
   input logic [2:0]    mode,
   input logic          busy,
   input logic          cal_err,
   input logic          wr_err,
   input logic [DW-1:0] off_coef,
   input logic [DW-1:0] fs_coef,
   input logic          res_valid
);
   logic misaligned;
   assign misaligned = (filt_word % FW'(FS_ALIGN)) != '0;

   // R2
   cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr && mode_in[2] && !(mode_in == 3'b101 && misaligned) |=> busy && mode == $past(mode_in));

   // R2
   busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> mode[2]);

   // R5
   cal_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mode_wr |=> busy || mode == 3'b010);

   // R6
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr && mode_in == 3'b101 && misaligned |=> !busy && cal_err && mode == 3'b010);

   // R11
   wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coef_wr && (mode == 3'b000 || mode == 3'b001) |=> wr_err && $stable(off_coef) && $stable(fs_coef));

   // R9
   res_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(raw_valid) && ($past(mode) == 3'b000 || $past(mode) == 3'b001));
endmodule

bind adc_cal_seq adc_cal_seq_chk #(.DW(DW), .FW(FW), .FS_ALIGN(FS_ALIGN)) u_chk (.*);

// File: tb/adc_cal_seq_test.sv
`timescale 1ns/1ps
module adc_cal_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [2:0]  mode_in = 3'b010;
   logic [9:0]  filt_word = 10'd0;
   logic        sinc3_sel = 1'b0, chop_en = 1'b0, gain_one = 1'b1;
   logic        raw_valid = 1'b0;
   logic [23:0] raw_data = '0;
   logic        coef_wr = 1'b0, coef_sel_fs = 1'b0;
   logic [23:0] coef_wdata = '0;
   logic [2:0]  mode;
   logic        busy, cal_err, wr_err, res_valid;
   logic [23:0] off_coef, fs_coef, res_data;

   int          n_run = 0, n_fail = 0;
   logic [23:0] e_off = 24'h800000, e_fs = 24'h800000;
   logic        e_calerr = 1'b0, e_wrerr = 1'b0;

   always #2 clk = ~clk;

   adc_cal_seq uut (.*);

   task automatic check(string req, longint act, longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] ref_corr(logic [23:0] r, logic [23:0] o, logic [23:0] f);
      longint d, p, s;
      d = longint'(r) - longint'(o);
      p = d * longint'(f);
      s = (p >>> 23) + 64'sh800000;
      if (s < 0) return 24'h000000;
      if (s > 64'shFFFFFF) return 24'hFFFFFF;
      return s[23:0];
   endfunction

   function automatic int ref_dur(logic [2:0] c, logic s3, logic ch, logic g1);
      int st;
      st = ch ? 2 : (s3 ? 3 : 4);
      if (c == 3'b101 && !g1) return 2 * st;
      return st;
   endfunction

   task automatic set_mode(logic [2:0] m);
      @(negedge clk); mode_wr = 1'b1; mode_in = m;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic send_raw(logic [23:0] d);
      @(negedge clk); raw_valid = 1'b1; raw_data = d;
      @(negedge clk); raw_valid = 1'b0;
   endtask

   task automatic write_coef(logic sel, logic [23:0] d);
      @(negedge clk); coef_wr = 1'b1; coef_sel_fs = sel; coef_wdata = d;
      @(negedge clk); coef_wr = 1'b0;
   endtask

   task automatic check_coefs(string req);
      check(req, off_coef, e_off);
      check(req, fs_coef, e_fs);
   endtask

   task automatic run_cal(logic [2:0] c);
      int d;
      logic [23:0] v;
      string tag;
      tag = c[0] ? "R4" : "R3";
      set_mode(c);
      if (c == 3'b101 && filt_word[3:0] != 4'd0) begin
         e_calerr = 1'b1;
         check("R6 mode", mode, 3'b010);
         check("R6 busy", busy, 0);
         check("R6 cal_err", cal_err, 1);
         check_coefs("R6 coefs");
         return;
      end
      check("R2 busy", busy, 1);
      check("R2 mode", mode, c);
      d = ref_dur(c, sinc3_sel, chop_en, gain_one);
      for (int i = 0; i < d - 1; i++) begin
         send_raw(24'($urandom));
         check(tag, busy, 1);
      end
      v = 24'($urandom);
      send_raw(v);
      check(tag, busy, 0);
      check("R5 mode", mode, 3'b010);
      if (c[0]) e_fs = v; else e_off = v;
      check_coefs("R5 coef");
   endtask

   task automatic conv_check(string req, logic [23:0] r);
      send_raw(r);
      check(req, res_valid, 1);
      check(req, res_data, ref_corr(r, e_off, e_fs));
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 mode", mode, 3'b010);
      check("R1 busy", busy, 0);
      check("R1 cal_err", cal_err, 0);
      check("R1 wr_err", wr_err, 0);
      check("R1 res_valid", res_valid, 0);
      check_coefs("R1 coefs");

      // R7 passthrough with reset coefficients
      set_mode(3'b000);
      conv_check("R7 pass", 24'h123456);
      conv_check("R7 pass", 24'h000001);
      set_mode(3'b010);

      // R3 zero-scale timing variants
      sinc3_sel = 0; chop_en = 0; run_cal(3'b100);
      sinc3_sel = 1; chop_en = 0; run_cal(3'b110);
      sinc3_sel = 0; chop_en = 1; run_cal(3'b100);
      // R4 full-scale timing variants
      filt_word = 10'h050;
      sinc3_sel = 0; chop_en = 0; gain_one = 1; run_cal(3'b101);
      sinc3_sel = 1; chop_en = 0; gain_one = 0; run_cal(3'b101);
      sinc3_sel = 0; chop_en = 0; gain_one = 0; run_cal(3'b111);
      // R6 refused internal full-scale
      filt_word = 10'h011; run_cal(3'b101);
      check("R6 sticky", cal_err, 1);

      // R10 writes in idle and power-down
      write_coef(1'b0, 24'h7FF000); e_off = 24'h7FF000; check_coefs("R10 idle off");
      set_mode(3'b011);
      write_coef(1'b1, 24'h900000); e_fs = 24'h900000; check_coefs("R10 pdown fs");
      // R9 no result in power-down or idle
      send_raw(24'h555555); check("R9 pdown", res_valid, 0);
      set_mode(3'b010);
      send_raw(24'h555555); check("R9 idle", res_valid, 0);

      // R11 write refused in continuous
      set_mode(3'b000);
      write_coef(1'b0, 24'h000123); e_wrerr = 1'b1;
      check("R11 wr_err", wr_err, 1); check_coefs("R11 coefs");
      conv_check("R7 scaled", 24'h912345);
      set_mode(3'b001);
      write_coef(1'b1, 24'h000123);
      check("R11 single", wr_err, 1); check_coefs("R11 single coefs");

      // R9 single mode
      conv_check("R9 single", 24'h6789AB);
      check("R9 single idle", mode, 3'b010);
      send_raw(24'h6789AB); check("R9 after single", res_valid, 0);

      // R8 saturation high and low
      write_coef(1'b0, 24'h000000); e_off = 24'h000000;
      write_coef(1'b1, 24'hFFFFFF); e_fs = 24'hFFFFFF;
      set_mode(3'b000);
      send_raw(24'hFFFFFF);
      check("R8 high", res_data, 24'hFFFFFF);
      set_mode(3'b010);
      write_coef(1'b0, 24'hFFFFFF); e_off = 24'hFFFFFF;
      set_mode(3'b000);
      send_raw(24'h000000);
      check("R8 low", res_data, 24'h000000);
      set_mode(3'b010);

      // random calibrations and conversions
      for (int k = 0; k < 40; k++) begin
         sinc3_sel = 1'($urandom); chop_en = 1'($urandom); gain_one = 1'($urandom);
         filt_word = ($urandom % 2) ? 10'({$urandom % 64, 4'd0}) : 10'($urandom);
         run_cal(3'($urandom % 4) + 3'd4);
         if (k % 4 == 3) begin
            write_coef(1'b1, 24'h700000 + 24'($urandom % 24'h200000)); e_fs = coef_wdata;
         end
         set_mode(3'b000);
         for (int j = 0; j < 3; j++) conv_check("R7 random", 24'($urandom));
         set_mode(3'b010);
      end
      check("R6 cal_err final", cal_err, longint'(e_calerr));
      check("R11 wr_err final", wr_err, longint'(e_wrerr));

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule